// File: doc/BRIEF.md
# Shared-Multiplier Channel Calibration Engine

This block keeps three calibration registers for each of 32 output channels, which sit in 4 groups of 8: an input code, a gain word and an offset word. Whenever one of these registers changes, the block recomputes that channel's calibrated code. It has only one multiplier, so the channels that a write touches are worked through one after another. While any of that work is outstanding, an active-low busy line stays low. The length of the busy pulse therefore grows with the number of channels that a single write reaches.

A write names a register kind, an addressing mode, a group, a position and a 16-bit data word. The modes reach one channel, one whole group, one position in every group, one position in every group except group 0, or every channel. Writes that arrive while busy is low are accepted and join the queue. A channel that is queued twice is computed only once, with its newest register contents.

Each result goes into one of two result banks, chosen by the channel's bank-select bit. The same store raises the channel's "new result" flag. A write to the bank-select bits holds busy low for a short fixed time and runs no multiply. A read port shows, for any one channel, both bank words, the select bit and the flag. The flags are cleared by a pulse from the downstream load logic.

Top module: `cal_engine`

## Requirements
- R1: After reset, every channel holds input 0x8000, gain 0xFFFF and offset 0x8000. Both bank words are 0x8000, the select bit is 0 (bank A), the new-result flag is 0, and busy_n is 1.
- R2: A channel's result is floor(input × (gain + 1) / 65536) + offset − 32768. A result below 0 is stored as 0, and a result above 65535 is stored as 65535.
- R3: wr_kind selects the register: 0 = input, 1 = gain, 2 = offset, 3 = bank select. The channel index is group × 8 + position. wr_mode selects the channels reached:
  - 0: the single channel (wr_grp, wr_pos).
  - 1: all 8 channels of group wr_grp.
  - 2: position wr_pos in groups 0 to 3.
  - 3: position wr_pos in groups 1 to 3.
  - 4: all 32 channels.
  - 5 to 7: no channel, so the write has no effect.
- R4: busy_n goes low in the cycle after an idle-time register write (wr_kind 0 to 2) that reaches n channels. It stays low for (n + 1) × STEP + TAIL cycles, where STEP = 600 ns and TAIL = 300 ns expressed in clock periods (6 and 3 at a 100 ns clock).
- R5: Register writes made while busy_n is low are accepted. A channel written again while it waits in the queue is computed once, with its newest contents. Three writes inside the lead-in phase that cover 2 distinct channels give a busy pulse of (2 + 1) × STEP + TAIL cycles.
- R6: A bank-select write (wr_kind 3) copies wr_data bit 0 into the select bit of each channel it reaches. When issued while idle, it holds busy_n low for SEL cycles (500 ns, so 5 at 100 ns) and changes no bank word.
- R7: A result is stored into bank B when the channel's select bit is 1 and into bank A when it is 0. The other bank keeps its value.
- R8: Storing a result sets that channel's new-result flag. A one-cycle pulse on fresh_clr clears every flag. A store in the same cycle as the pulse wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_kind | input | 2 | Register kind (R3) |
| wr_mode | input | 3 | Addressing mode (R3) |
| wr_grp | input | 2 | Group number |
| wr_pos | input | 3 | Position inside the group |
| wr_data | input | 16 | Write data |
| fresh_clr | input | 1 | Clears all new-result flags |
| rd_ch | input | 5 | Channel shown on the read port |
| busy_n | output | 1 | Low while work is pending |
| rd_x2a | output | 16 | Bank A result of rd_ch |
| rd_x2b | output | 16 | Bank B result of rd_ch |
| rd_sel | output | 1 | Bank-select bit of rd_ch |
| rd_fresh | output | 1 | New-result flag of rd_ch |

## Verification
A queue bit that is lost or stuck shows up at the end of the busy pulse: the pulse is short or long by whole multiples of STEP, and the skipped channel keeps its old result word, which the read port shows as soon as busy_n rises. A mis-decoded addressing mode changes the channel count, so it is visible in the same busy length, and the untouched neighbour channels are read back to confirm it. A wrong bank choice or a bad saturation shows up on the first read after the store, because results are written directly into the readable banks.

// File: rtl/cal_pkg.sv
package cal_pkg;
   typedef enum logic [1:0] {
      K_X1  = 2'd0,
      K_GN  = 2'd1,
      K_OF  = 2'd2,
      K_SEL = 2'd3
   } kind_e;

   typedef enum logic [2:0] {
      M_ONE   = 3'd0,
      M_GROUP = 3'd1,
      M_POS   = 3'd2,
      M_POSHI = 3'd3,
      M_ALL   = 3'd4
   } mode_e;

   typedef enum logic [2:0] {
      S_IDLE,
      S_LEAD,
      S_CALC,
      S_TAIL,
      S_SEL
   } seq_e;

   function automatic int ns_to_cyc(input int ns, input int clk_ns);
      return (ns + clk_ns - 1) / clk_ns;
   endfunction
endpackage

// File: rtl/cal_addr_dec.sv
module cal_addr_dec #(
   parameter int NGRP  = 4,
   parameter int GSIZE = 8,
   localparam int NCH   = NGRP * GSIZE,
   localparam int GRP_W = (NGRP > 1) ? $clog2(NGRP) : 1,
   localparam int POS_W = (GSIZE > 1) ? $clog2(GSIZE) : 1
) (
   input  logic [2:0]       mode,
   input  logic [GRP_W-1:0] grp,
   input  logic [POS_W-1:0] pos,
   output logic [NCH-1:0]   mask
);
   import cal_pkg::*;

   for (genvar g = 0; g < NGRP; g++) begin : g_grp
      for (genvar p = 0; p < GSIZE; p++) begin : g_pos
         localparam int IDX = g * GSIZE + p;
         logic hit_g, hit_p;
         assign hit_g = (grp == GRP_W'(g));
         assign hit_p = (pos == POS_W'(p));
         always_comb begin
            unique case (mode)
               M_ONE:   mask[IDX] = hit_g & hit_p;
               M_GROUP: mask[IDX] = hit_g;
               M_POS:   mask[IDX] = hit_p;
               M_POSHI: mask[IDX] = hit_p & (g != 0);
               M_ALL:   mask[IDX] = 1'b1;
               default: mask[IDX] = 1'b0;
            endcase
         end
      end
   end
endmodule

// File: rtl/cal_mult.sv
module cal_mult #(
   parameter int DW = 16
) (
   input  logic [DW-1:0] x1,
   input  logic [DW-1:0] gain,
   input  logic [DW-1:0] offs,
   output logic [DW-1:0] x2
);
   localparam int PW = 2 * DW + 1;
   localparam int SW = PW + 1;
   localparam logic [SW-1:0] MID  = SW'(1) << (DW - 1);
   localparam logic [SW-1:0] MAXV = (SW'(1) << DW) - SW'(1);

   logic [DW:0]   gain_p1;
   logic [PW-1:0] prod;
   logic [SW-1:0] sum;

   always_comb begin
      gain_p1 = {1'b0, gain} + (DW + 1)'(1);
      prod    = PW'(x1) * PW'(gain_p1);
      sum     = SW'(prod >> DW) + SW'(offs) - MID;
      if (sum[SW-1])
         x2 = '0;
      else if (sum > MAXV)
         x2 = '1;
      else
         x2 = sum[DW-1:0];
   end
endmodule

// File: rtl/cal_regfile.sv
module cal_regfile #(
   parameter int NCH = 32,
   parameter int DW  = 16,
   localparam int CH_W = $clog2(NCH)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en,
   input  logic [1:0]      wr_kind,
   input  logic [NCH-1:0]  wr_mask,
   input  logic [DW-1:0]   wr_data,
   input  logic [CH_W-1:0] op_ch,
   output logic [DW-1:0]   op_x1,
   output logic [DW-1:0]   op_gain,
   output logic [DW-1:0]   op_offs,
   input  logic            res_we,
   input  logic [CH_W-1:0] res_ch,
   input  logic [DW-1:0]   res_val,
   input  logic            fresh_clr,
   input  logic [CH_W-1:0] rd_ch,
   output logic [DW-1:0]   rd_x2a,
   output logic [DW-1:0]   rd_x2b,
   output logic            rd_sel,
   output logic            rd_fresh
);
   import cal_pkg::*;

   localparam logic [DW-1:0] MIDV = DW'(1) << (DW - 1);

   logic [DW-1:0]  x1_q   [NCH];
   logic [DW-1:0]  gn_q   [NCH];
   logic [DW-1:0]  of_q   [NCH];
   logic [DW-1:0]  x2a_q  [NCH];
   logic [DW-1:0]  x2b_q  [NCH];
   logic [NCH-1:0] sel_q;
   logic [NCH-1:0] fresh_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NCH; i++) begin
            x1_q[i]  <= MIDV;
            gn_q[i]  <= '1;
            of_q[i]  <= MIDV;
            x2a_q[i] <= MIDV;
            x2b_q[i] <= MIDV;
         end
         sel_q   <= '0;
         fresh_q <= '0;
      end else begin
         for (int i = 0; i < NCH; i++) begin
            if (wr_en && wr_mask[i]) begin
               unique case (kind_e'(wr_kind))
                  K_X1:  x1_q[i]  <= wr_data;
                  K_GN:  gn_q[i]  <= wr_data;
                  K_OF:  of_q[i]  <= wr_data;
                  K_SEL: sel_q[i] <= wr_data[0];
               endcase
            end
            if (res_we && res_ch == CH_W'(i)) begin
               if (sel_q[i]) x2b_q[i] <= res_val;
               else          x2a_q[i] <= res_val;
               fresh_q[i] <= 1'b1;
            end else if (fresh_clr) begin
               fresh_q[i] <= 1'b0;
            end
         end
      end
   end

   assign op_x1    = x1_q[op_ch];
   assign op_gain  = gn_q[op_ch];
   assign op_offs  = of_q[op_ch];
   assign rd_x2a   = x2a_q[rd_ch];
   assign rd_x2b   = x2b_q[rd_ch];
   assign rd_sel   = sel_q[rd_ch];
   assign rd_fresh = fresh_q[rd_ch];

   // R8
   fresh_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_we |=> fresh_q[$past(res_ch)]);

   // R7
   bank_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (res_we && !sel_q[res_ch]) |=> (x2b_q[$past(res_ch)] == $past(x2b_q[res_ch])));
endmodule

// File: rtl/cal_seq.sv
module cal_seq #(
   parameter int NCH      = 32,
   parameter int STEP_CYC = 6,
   parameter int TAIL_CYC = 3,
   parameter int SEL_CYC  = 5,
   localparam int CH_W  = $clog2(NCH),
   localparam int MAXC  = (STEP_CYC > TAIL_CYC)
                          ? ((STEP_CYC > SEL_CYC) ? STEP_CYC : SEL_CYC)
                          : ((TAIL_CYC > SEL_CYC) ? TAIL_CYC : SEL_CYC),
   localparam int CNT_W = $clog2(MAXC + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NCH-1:0]  add_mask,
   input  logic            sel_req,
   output logic            busy_n,
   output logic [CH_W-1:0] cur_ch,
   output logic            res_we
);
   import cal_pkg::*;

   localparam logic [CNT_W-1:0] STEP_L = CNT_W'(STEP_CYC - 1);
   localparam logic [CNT_W-1:0] TAIL_L = CNT_W'(TAIL_CYC - 1);
   localparam logic [CNT_W-1:0] SEL_L  = CNT_W'(SEL_CYC - 1);

   seq_e             st_q, st_d;
   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic [NCH-1:0]   pend_q, remain;
   logic [CH_W-1:0]  cur_q, cur_d;
   logic             done;

   function automatic logic [CH_W-1:0] first_set(input logic [NCH-1:0] v);
      logic [CH_W-1:0] r;
      r = '0;
      for (int i = NCH - 1; i >= 0; i--)
         if (v[i]) r = CH_W'(i);
      return r;
   endfunction

   always_comb begin
      done   = (cnt_q == '0);
      res_we = (st_q == S_CALC) && done;
      remain = (pend_q & ~(res_we ? (NCH'(1) << cur_q) : '0)) | add_mask;
      st_d   = st_q;
      cnt_d  = done ? cnt_q : cnt_q - CNT_W'(1);
      cur_d  = cur_q;
      unique case (st_q)
         S_IDLE: begin
            if (add_mask != '0) begin
               st_d  = S_LEAD;
               cnt_d = STEP_L;
            end else if (sel_req) begin
               st_d  = S_SEL;
               cnt_d = SEL_L;
            end
         end
         S_LEAD: begin
            if (done) begin
               st_d  = S_CALC;
               cnt_d = STEP_L;
               cur_d = first_set(remain);
            end
         end
         S_CALC: begin
            if (done) begin
               if (remain != '0) begin
                  cnt_d = STEP_L;
                  cur_d = first_set(remain);
               end else begin
                  st_d  = S_TAIL;
                  cnt_d = TAIL_L;
               end
            end
         end
         S_TAIL: begin
            if (remain != '0) begin
               st_d  = S_CALC;
               cnt_d = STEP_L;
               cur_d = first_set(remain);
            end else if (done) begin
               st_d = S_IDLE;
            end
         end
         S_SEL: begin
            if (done) begin
               if (remain != '0) begin
                  st_d  = S_LEAD;
                  cnt_d = STEP_L;
               end else begin
                  st_d = S_IDLE;
               end
            end
         end
         default: st_d = S_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= S_IDLE;
         cnt_q  <= '0;
         pend_q <= '0;
         cur_q  <= '0;
      end else begin
         st_q   <= st_d;
         cnt_q  <= cnt_d;
         pend_q <= remain;
         cur_q  <= cur_d;
      end
   end

   assign busy_n = (st_q == S_IDLE);
   assign cur_ch = cur_q;

   // R5
   pend_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q != '0) |-> !busy_n);
endmodule

// File: rtl/cal_engine.sv
module cal_engine #(
   parameter int NGRP   = 4,
   parameter int GSIZE  = 8,
   parameter int DW     = 16,
   parameter int CLK_NS = 100,
   parameter int STEP_NS = 600,
   parameter int TAIL_NS = 300,
   parameter int SEL_NS  = 500,
   localparam int NCH   = NGRP * GSIZE,
   localparam int CH_W  = $clog2(NCH),
   localparam int GRP_W = (NGRP > 1) ? $clog2(NGRP) : 1,
   localparam int POS_W = (GSIZE > 1) ? $clog2(GSIZE) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [1:0]       wr_kind,
   input  logic [2:0]       wr_mode,
   input  logic [GRP_W-1:0] wr_grp,
   input  logic [POS_W-1:0] wr_pos,
   input  logic [DW-1:0]    wr_data,
   input  logic             fresh_clr,
   input  logic [CH_W-1:0]  rd_ch,
   output logic             busy_n,
   output logic [DW-1:0]    rd_x2a,
   output logic [DW-1:0]    rd_x2b,
   output logic             rd_sel,
   output logic             rd_fresh
);
   import cal_pkg::*;

   localparam int STEP_CYC = ns_to_cyc(STEP_NS, CLK_NS);
   localparam int TAIL_CYC = ns_to_cyc(TAIL_NS, CLK_NS);
   localparam int SEL_CYC  = ns_to_cyc(SEL_NS, CLK_NS);

   if (NGRP < 2 || GSIZE < 2) begin : g_bad_geom
      $error("cal_engine: need at least 2 groups of 2 channels");
   end
   if (DW < 2) begin : g_bad_dw
      $error("cal_engine: data width too small");
   end
   if (CLK_NS < 1 || STEP_CYC < 1 || TAIL_CYC < 1 || SEL_CYC < 1) begin : g_bad_time
      $error("cal_engine: timing parameters give empty phases");
   end

   logic [NCH-1:0]  mask, add_mask;
   logic            sel_req;
   logic [CH_W-1:0] cur_ch;
   logic            res_we;
   logic [DW-1:0]   op_x1, op_gain, op_offs, res_val;

   cal_addr_dec #(.NGRP(NGRP), .GSIZE(GSIZE)) u_dec (
      .mode (wr_mode),
      .grp  (wr_grp),
      .pos  (wr_pos),
      .mask (mask)
   );

   assign add_mask = (wr_en && kind_e'(wr_kind) != K_SEL) ? mask : '0;
   assign sel_req  = wr_en && kind_e'(wr_kind) == K_SEL && (mask != '0);

   cal_seq #(
      .NCH(NCH), .STEP_CYC(STEP_CYC), .TAIL_CYC(TAIL_CYC), .SEL_CYC(SEL_CYC)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .add_mask (add_mask),
      .sel_req  (sel_req),
      .busy_n   (busy_n),
      .cur_ch   (cur_ch),
      .res_we   (res_we)
   );

   cal_mult #(.DW(DW)) u_mult (
      .x1   (op_x1),
      .gain (op_gain),
      .offs (op_offs),
      .x2   (res_val)
   );

   cal_regfile #(.NCH(NCH), .DW(DW)) u_rf (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_kind   (wr_kind),
      .wr_mask   (mask),
      .wr_data   (wr_data),
      .op_ch     (cur_ch),
      .op_x1     (op_x1),
      .op_gain   (op_gain),
      .op_offs   (op_offs),
      .res_we    (res_we),
      .res_ch    (cur_ch),
      .res_val   (res_val),
      .fresh_clr (fresh_clr),
      .rd_ch     (rd_ch),
      .rd_x2a    (rd_x2a),
      .rd_x2b    (rd_x2b),
      .rd_sel    (rd_sel),
      .rd_fresh  (rd_fresh)
   );

   // R4
   calc_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_kind != 2'd3 && wr_mode <= 3'd4) |=> !busy_n);

   // R6
   sel_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_kind == 2'd3 && wr_mode <= 3'd4) |=> !busy_n);
endmodule

// File: tb/cal_engine_tb.sv
module cal_engine_tb;
   localparam int CLK_NS  = 100;
   localparam int STEP    = 600 / CLK_NS;
   localparam int TAIL    = 300 / CLK_NS;
   localparam int SELC    = 500 / CLK_NS;
   localparam int NVEC    = 7;

   typedef struct packed {
      logic [1:0]  kind;
      logic [2:0]  mode;
      logic [1:0]  grp;
      logic [2:0]  pos;
      logic [15:0] data;
      logic [5:0]  nch;
      logic [4:0]  chk_ch;
      logic        chk_b;
      logic [15:0] exp_v;
   } vec_t;

   localparam vec_t VEC [NVEC] = '{
      '{2'd0, 3'd0, 2'd0, 3'd5, 16'h4000, 6'd1,  5'd5,  1'b0, 16'h4000},
      '{2'd1, 3'd1, 2'd2, 3'd0, 16'h7FFF, 6'd8,  5'd16, 1'b0, 16'h4000},
      '{2'd2, 3'd2, 2'd0, 3'd3, 16'h9000, 6'd4,  5'd19, 1'b0, 16'h5000},
      '{2'd2, 3'd3, 2'd0, 3'd3, 16'h0000, 6'd3,  5'd27, 1'b0, 16'h0000},
      '{2'd0, 3'd4, 2'd0, 3'd0, 16'hFFFF, 6'd32, 5'd19, 1'b0, 16'h0000},
      '{2'd3, 3'd0, 2'd0, 3'd2, 16'h0001, 6'd0,  5'd2,  1'b0, 16'hFFFF},
      '{2'd0, 3'd0, 2'd0, 3'd2, 16'h1234, 6'd1,  5'd2,  1'b1, 16'h1234}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_kind = '0;
   logic [2:0]  wr_mode = '0;
   logic [1:0]  wr_grp = '0;
   logic [2:0]  wr_pos = '0;
   logic [15:0] wr_data = '0;
   logic        fresh_clr = 1'b0;
   logic [4:0]  rd_ch = '0;
   logic        busy_n;
   logic [15:0] rd_x2a, rd_x2b;
   logic        rd_sel, rd_fresh;

   int n_chk = 0;
   int n_bad = 0;
   int cyc = 0;

   cal_engine #(.CLK_NS(CLK_NS)) u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_kind(wr_kind),
      .wr_mode(wr_mode), .wr_grp(wr_grp), .wr_pos(wr_pos), .wr_data(wr_data),
      .fresh_clr(fresh_clr), .rd_ch(rd_ch), .busy_n(busy_n),
      .rd_x2a(rd_x2a), .rd_x2b(rd_x2b), .rd_sel(rd_sel), .rd_fresh(rd_fresh)
   );

   always #(CLK_NS / 2) clk = ~clk;

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 100000) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: run hung, actual %0d cycles expected below 100000", cyc);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] k, input logic [2:0] m, input logic [1:0] g,
                     input logic [2:0] p, input logic [15:0] d);
      wr_kind = k; wr_mode = m; wr_grp = g; wr_pos = p; wr_data = d;
      wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic wait_idle(output int n);
      n = 0;
      while (!busy_n && n < 5000) begin
         n++;
         @(negedge clk);
      end
   endtask

   task automatic peek(input logic [4:0] ch);
      rd_ch = ch;
      #1;
   endtask

   initial begin
      int blen;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check("R1 busy_n", int'(busy_n), 1);
      peek(5'd0);
      check("R1 bank A", int'(rd_x2a), 'h8000);
      check("R1 bank B", int'(rd_x2b), 'h8000);
      check("R1 select", int'(rd_sel), 0);
      check("R1 flag", int'(rd_fresh), 0);
      peek(5'd31);
      check("R1 bank A last", int'(rd_x2a), 'h8000);

      // R2/R3/R4/R6/R7 table walk
      for (int i = 0; i < NVEC; i++) begin
         wr(VEC[i].kind, VEC[i].mode, VEC[i].grp, VEC[i].pos, VEC[i].data);
         wait_idle(blen);
         if (VEC[i].kind == 2'd3)
            check("R6 select busy length", blen, SELC);
         else
            check("R4 busy length", blen, (int'(VEC[i].nch) + 1) * STEP + TAIL);
         peek(VEC[i].chk_ch);
         check("R2/R3 result", VEC[i].chk_b ? int'(rd_x2b) : int'(rd_x2a), int'(VEC[i].exp_v));
      end

      // R2 saturation high and offset arithmetic, R3 neighbour untouched
      peek(5'd3);
      check("R2 clip high", int'(rd_x2a), 'hFFFF);
      peek(5'd11);
      check("R3 mode3 reached ch11", int'(rd_x2a), 'h7FFF);
      peek(5'd16);
      check("R2 gain half", int'(rd_x2a), 'h7FFF);
      // R7 other bank kept, select bit set
      peek(5'd2);
      check("R7 bank A kept", int'(rd_x2a), 'hFFFF);
      check("R6 select bit", int'(rd_sel), 1);
      peek(5'd1);
      check("R6 neighbour select", int'(rd_sel), 0);

      // R3 reserved mode ignored
      wr(2'd0, 3'd5, 2'd0, 3'd0, 16'h0000);
      check("R3 reserved mode busy_n", int'(busy_n), 1);
      peek(5'd0);
      check("R3 reserved mode result", int'(rd_x2a), 'hFFFF);

      // R5 writes while busy, repeated channel computed once with newest data
      wr(2'd0, 3'd0, 2'd0, 3'd7, 16'h1000);
      wr(2'd0, 3'd0, 2'd0, 3'd7, 16'h2000);
      wr(2'd0, 3'd0, 2'd0, 3'd6, 16'h0ABC);
      wait_idle(blen);
      check("R5 merged busy length", blen + 2, 3 * STEP + TAIL);
      peek(5'd7);
      check("R5 newest data", int'(rd_x2a), 'h2000);
      peek(5'd6);
      check("R5 queued channel", int'(rd_x2a), 'h0ABC);

      // R8 flag clear and set
      peek(5'd5);
      check("R8 flag set earlier", int'(rd_fresh), 1);
      fresh_clr = 1'b1;
      @(negedge clk);
      fresh_clr = 1'b0;
      peek(5'd5);
      check("R8 flag cleared", int'(rd_fresh), 0);
      wr(2'd0, 3'd0, 2'd0, 3'd5, 16'h0100);
      wait_idle(blen);
      peek(5'd5);
      check("R8 flag after store", int'(rd_fresh), 1);
      check("R2 unity gain", int'(rd_x2a), 'h0100);
      peek(5'd4);
      check("R8 neighbour flag", int'(rd_fresh), 0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule